// File: doc/BRIEF.md
# Fault-Checked CRT Signature Recombiner

This block finishes a fault-hardened CRT signature. Two redundant half-signatures come from the exponentiation stage. One was computed modulo p·r and the other modulo q·r, where r is a small random prime shared by both halves. The block first confirms that the two halves agree modulo r. It then reduces each half to its own prime and joins the two residues with Garner's formula. Before it releases the result, it confirms that the joined value still matches each half modulo its prime. A failed check at either point replaces the signature with a fixed error code, so a faulty value never leaves the block.

All arithmetic goes through one bit-serial remainder unit, which handles a 64-bit dividend and a 32-bit modulus in 64 steps. A small sequencer schedules eight reductions in a fixed order. A caller places the operands on the inputs and pulses `start`. The operands are captured at that edge. The caller then waits for the one-cycle `done` pulse and reads `sig` and `fault` in the same cycle.

Top module: `crt_fault_recombiner`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `fault` are 0 and `sig` is 0.
- R2: A `start` seen while idle captures all six operands. A `start` seen while an operation is running is ignored. Operand changes after the capturing edge do not affect the result.
- R3: Each accepted `start` yields exactly one `done` pulse, one cycle wide. `sig` and `fault` are valid in that cycle and hold until the next `done`.
- R4: If `half_p mod mod_r` differs from `half_q mod mod_r`, the block ends the operation early with `fault`=1 and `sig` equal to the error code (default 0x0000000000000000).
- R5: With consistent inputs and `inv_q`·`mod_q` ≡ 1 (mod `mod_p`), `sig` = ((((Sp − (Sq mod p)) mod p)·`inv_q`) mod p)·`mod_q` + Sq and `fault`=0. Here Sp = `half_p mod mod_p` and Sq = `half_q mod mod_q`. This equals the unique value below p·q that is congruent to each half modulo its prime.
- R6: When Sp < (Sq mod p), the difference is wrapped by adding p, so the result is still correct.
- R7: If the recombined value S fails S mod p = Sp or S mod q = Sq (for example, when `inv_q` is not the inverse of q modulo p), then `fault`=1 and `sig` is the error code.
- R8: `done` arrives no later than 8·(64+2)+2 cycles after the accepted `start`. An early exit under R4 arrives no later than 2·(64+2)+2 cycles after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| half_p | input | 64 | Redundant half-signature modulo p·r |
| half_q | input | 64 | Redundant half-signature modulo q·r |
| mod_p | input | 32 | First secret prime p |
| mod_q | input | 32 | Second secret prime q |
| mod_r | input | 32 | Random check prime r |
| inv_q | input | 32 | Inverse of q modulo p |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Fault detected; valid with done |
| sig | output | 64 | Signature, or the error code when fault is set |

## Verification
The assertions watch the following on every cycle:
- that `done` is a single-cycle pulse that only follows a busy phase;
- that a flagged result carries the error code;
- that the captured primes stay still while the sequencer runs;
- that every remainder the shared reducer delivers lies below its modulus;
- that no operation outlasts the latency bound.

Only the bench's scenarios can show that the numbers are right. These include the recombined value against a separate CRT model, the wrapped negative difference, and the two kinds of detected fault. The same holds for ignoring a second `start` mid-operation and for the early exit on an r mismatch.

// File: rtl/crt_rec_pkg.sv
package crt_rec_pkg;

  localparam int PW = 32;
  localparam int DW = 2 * PW;

  typedef logic [PW-1:0] res_t;
  typedef logic [DW-1:0] wide_t;

  typedef enum logic [2:0] {
    OP_RP,   // half_p mod r
    OP_RQ,   // half_q mod r, compared with OP_RP
    OP_SP,   // half_p mod p
    OP_SQ,   // half_q mod q
    OP_SQP,  // Sq mod p
    OP_T,    // (diff * iq) mod p
    OP_CP,   // S mod p
    OP_CQ    // S mod q
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT
  } st_e;

  // a - b modulo m, for a, b < m
  function automatic res_t mod_sub(res_t a, res_t b, res_t m);
    logic [PW:0] d;
    d = {1'b0, a} - {1'b0, b};
    if (a < b) d = d + {1'b0, m};
    return d[PW-1:0];
  endfunction

  function automatic wide_t mul_w(res_t a, res_t b);
    return wide_t'(a) * wide_t'(b);
  endfunction

  // t*q + sq, never exceeds p*q-1 when t<p and sq<q
  function automatic wide_t compose(res_t t, res_t q, res_t sq);
    return mul_w(t, q) + wide_t'(sq);
  endfunction

endpackage

// File: rtl/crt_mod_reducer.sv
module crt_mod_reducer #(
  parameter int DW = 64,
  parameter int MW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [MW-1:0] modulus,
  output logic          rdy,
  output logic [MW-1:0] rem,
  output logic [MW-1:0] mod_used
);

  localparam int CW = $clog2(DW + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [MW-1:0] acc;
  logic [MW-1:0] m_q;
  logic [MW:0]   nxt;
  logic [MW:0]   trial;

  always_comb begin
    nxt   = {acc, sh[DW-1]};
    trial = nxt - {1'b0, m_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sh   <= '0;
      acc  <= '0;
      m_q  <= '0;
      rdy  <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        cnt  <= CW'(DW);
        sh   <= dividend;
        acc  <= '0;
        m_q  <= modulus;
      end else if (busy) begin
        sh  <= sh << 1;
        acc <= (nxt >= {1'b0, m_q}) ? trial[MW-1:0] : nxt[MW-1:0];
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          rdy  <= 1'b1;
        end
      end
    end
  end

  assign rem      = acc;
  assign mod_used = m_q;

endmodule

// File: rtl/crt_garner_step.sv
module crt_garner_step
  import crt_rec_pkg::*;
(
  input  res_t  sp,
  input  res_t  sqp,
  input  res_t  p,
  input  res_t  iq,
  input  res_t  t,
  input  res_t  q,
  input  res_t  sq,
  output res_t  diff,
  output wide_t prod,
  output wide_t s_new
);

  always_comb begin
    diff  = mod_sub(sp, sqp, p);
    prod  = mul_w(diff, iq);
    s_new = compose(t, q, sq);
  end

endmodule

// File: rtl/crt_fault_recombiner.sv
module crt_fault_recombiner
  import crt_rec_pkg::*;
#(
  parameter logic [63:0] ERR_CODE = 64'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] half_p,
  input  logic [63:0] half_q,
  input  logic [31:0] mod_p,
  input  logic [31:0] mod_q,
  input  logic [31:0] mod_r,
  input  logic [31:0] inv_q,
  output logic        done,
  output logic        fault,
  output logic [63:0] sig
);

  st_e   st;
  op_e   op;

  res_t  lat_p, lat_q, lat_r, lat_iq;
  wide_t lat_hp, lat_hq;

  res_t  r_a, sp_v, sq_v, sqp_v, cp_v;
  wide_t s_v;

  // shared reducer
  logic  red_go;
  wide_t red_div;
  res_t  red_mod_in;
  logic  red_rdy;
  res_t  red_rem;
  res_t  red_mod;

  // garner arithmetic
  res_t  g_diff;
  wide_t g_prod;
  wide_t g_snew;

  // named events
  logic  busy_w;
  logic  chk_r_fail;
  logic  chk_post_fail;

  assign red_go = (st == ST_LAUNCH);
  assign busy_w = (st != ST_IDLE);

  always_comb begin
    red_div    = lat_hp;
    red_mod_in = lat_p;
    case (op)
      OP_RP:  begin red_div = lat_hp;          red_mod_in = lat_r; end
      OP_RQ:  begin red_div = lat_hq;          red_mod_in = lat_r; end
      OP_SP:  begin red_div = lat_hp;          red_mod_in = lat_p; end
      OP_SQ:  begin red_div = lat_hq;          red_mod_in = lat_q; end
      OP_SQP: begin red_div = wide_t'(sq_v);   red_mod_in = lat_p; end
      OP_T:   begin red_div = g_prod;          red_mod_in = lat_p; end
      OP_CP:  begin red_div = s_v;             red_mod_in = lat_p; end
      OP_CQ:  begin red_div = s_v;             red_mod_in = lat_q; end
      default: begin red_div = lat_hp;         red_mod_in = lat_p; end
    endcase
  end

  crt_mod_reducer #(.DW(DW), .MW(PW)) u_red (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (red_go),
    .dividend (red_div),
    .modulus  (red_mod_in),
    .rdy      (red_rdy),
    .rem      (red_rem),
    .mod_used (red_mod)
  );

  crt_garner_step u_garner (
    .sp    (sp_v),
    .sqp   (sqp_v),
    .p     (lat_p),
    .iq    (lat_iq),
    .t     (red_rem),
    .q     (lat_q),
    .sq    (sq_v),
    .diff  (g_diff),
    .prod  (g_prod),
    .s_new (g_snew)
  );

  assign chk_r_fail    = (st == ST_WAIT) && red_rdy && (op == OP_RQ) &&
                         (red_rem != r_a);
  assign chk_post_fail = (st == ST_WAIT) && red_rdy && (op == OP_CQ) &&
                         ((cp_v != sp_v) || (red_rem != sq_v));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op     <= OP_RP;
      lat_p  <= '0;
      lat_q  <= '0;
      lat_r  <= '0;
      lat_iq <= '0;
      lat_hp <= '0;
      lat_hq <= '0;
      r_a    <= '0;
      sp_v   <= '0;
      sq_v   <= '0;
      sqp_v  <= '0;
      cp_v   <= '0;
      s_v    <= '0;
      done   <= 1'b0;
      fault  <= 1'b0;
      sig    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            lat_p  <= mod_p;
            lat_q  <= mod_q;
            lat_r  <= mod_r;
            lat_iq <= inv_q;
            lat_hp <= half_p;
            lat_hq <= half_q;
            op     <= OP_RP;
            st     <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: st <= ST_WAIT;
        ST_WAIT: begin
          if (red_rdy) begin
            st <= ST_LAUNCH;
            case (op)
              OP_RP: begin r_a <= red_rem; op <= OP_RQ; end
              OP_RQ: begin
                if (chk_r_fail) begin
                  done  <= 1'b1;
                  fault <= 1'b1;
                  sig   <= ERR_CODE;
                  st    <= ST_IDLE;
                end else begin
                  op <= OP_SP;
                end
              end
              OP_SP:  begin sp_v  <= red_rem; op <= OP_SQ;  end
              OP_SQ:  begin sq_v  <= red_rem; op <= OP_SQP; end
              OP_SQP: begin sqp_v <= red_rem; op <= OP_T;   end
              OP_T:   begin s_v   <= g_snew;  op <= OP_CP;  end
              OP_CP:  begin cp_v  <= red_rem; op <= OP_CQ;  end
              OP_CQ: begin
                done  <= 1'b1;
                fault <= chk_post_fail;
                sig   <= chk_post_fail ? ERR_CODE : s_v;
                st    <= ST_IDLE;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/crt_fault_recombiner_chk.sv
module crt_fault_recombiner_chk
  import crt_rec_pkg::*;
#(
  parameter logic [63:0] ERR_CODE = 64'h0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [63:0] sig,
  input logic        red_rdy,
  input res_t        red_rem,
  input res_t        red_mod,
  input res_t        lat_p,
  input res_t        lat_q,
  input res_t        lat_r
);

  localparam int LAT_MAX = 8 * (DW + 2) + 2;

  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     lat_cnt <= '0;
    else if (!busy) lat_cnt <= '0;
    else            lat_cnt <= lat_cnt + 16'd1;
  end

  // R3: done is one cycle wide
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: done only closes a busy phase
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R4 / R7: a flagged result carries the error code
  assert_err_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (sig == ERR_CODE));

  // R2: captured primes are stable while the sequencer runs
  assert_operands_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lat_p) && $stable(lat_q) && $stable(lat_r)));

  // R5: every reduction lands below its modulus
  assert_rem_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (red_rdy && (red_mod != '0)) |-> (red_rem < red_mod));

  // R8: no operation outlasts the bound
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat_cnt <= 16'(LAT_MAX)));

endmodule

bind crt_fault_recombiner crt_fault_recombiner_chk #(.ERR_CODE(ERR_CODE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy_w),
  .done    (done),
  .fault   (fault),
  .sig     (sig),
  .red_rdy (red_rdy),
  .red_rem (red_rem),
  .red_mod (red_mod),
  .lat_p   (lat_p),
  .lat_q   (lat_q),
  .lat_r   (lat_r)
);

// File: tb/crt_fault_recombiner_tb.sv
module crt_fault_recombiner_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int LAT_FULL  = 8 * (64 + 2) + 2;
  localparam int LAT_ABORT = 2 * (64 + 2) + 2;

  // kind: 0 clean, 1 half_q disturbed (r mismatch), 2 wrong inverse
  localparam logic [31:0] VP [0:NV-1] = '{32'd101, 32'd65521, 32'd4294967291, 32'd1000003,
                                          32'd101, 32'd65521, 32'd4294967291, 32'd101};
  localparam logic [31:0] VQ [0:NV-1] = '{32'd103, 32'd65519, 32'd4294967279, 32'd65521,
                                          32'd103, 32'd65519, 32'd4294967279, 32'd103};
  localparam logic [31:0] VR [0:NV-1] = '{32'd107, 32'd65497, 32'd2147483647, 32'd101,
                                          32'd107, 32'd65497, 32'd4294967231, 32'd107};
  localparam logic [63:0] VM [0:NV-1] = '{64'd123456, 64'h0123_4567_89AB_CDEF,
                                          64'hFEDC_BA98_7654_3210, 64'd999,
                                          64'd203, 64'h0000_0BAD_F00D_1234,
                                          64'h7777_1234_ABCD_0001, 64'd205};
  localparam int VK [0:NV-1] = '{0, 0, 0, 0, 0, 1, 2, 2};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] half_p = '0, half_q = '0;
  logic [31:0] mod_p = '0, mod_q = '0, mod_r = '0, inv_q = '0;
  logic        done, fault;
  logic [63:0] sig;

  int checks = 0;
  int errors = 0;
  int total_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_fault_recombiner u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .half_p(half_p), .half_q(half_q),
    .mod_p(mod_p), .mod_q(mod_q), .mod_r(mod_r), .inv_q(inv_q),
    .done(done), .fault(fault), .sig(sig)
  );

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", total_cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modinv(input logic [31:0] a, input logic [31:0] m);
    longint t0, t1, r0, r1, qq, tmp;
    t0 = 0; t1 = 1; r0 = longint'(m); r1 = longint'(a);
    while (r1 != 0) begin
      qq = r0 / r1;
      tmp = r0 - qq * r1; r0 = r1; r1 = tmp;
      tmp = t0 - qq * t1; t0 = t1; t1 = tmp;
    end
    if (t0 < 0) t0 = t0 + longint'(m);
    return t0[31:0];
  endfunction

  function automatic void ref_model(input logic [31:0] p, q, r, iq,
                                    input logic [63:0] hp, hq,
                                    output logic [63:0] s_e, output logic f_e);
    logic [63:0] bp, bq, br, bi, sp, sq, d, t, s;
    bp = {32'b0, p}; bq = {32'b0, q}; br = {32'b0, r}; bi = {32'b0, iq};
    if ((hp % br) != (hq % br)) begin
      s_e = 64'h0; f_e = 1'b1; return;
    end
    sp = hp % bp;
    sq = hq % bq;
    d  = (sp + bp - (sq % bp)) % bp;
    t  = (d * bi) % bp;
    s  = t * bq + sq;
    if (((s % bp) != sp) || ((s % bq) != sq)) begin
      s_e = 64'h0; f_e = 1'b1;
    end else begin
      s_e = s; f_e = 1'b0;
    end
  endfunction

  task automatic run_op(input logic [31:0] p, q, r, iq, input logic [63:0] hp, hq,
                        output logic [63:0] s_o, output logic f_o, output int cyc);
    @(negedge clk);
    mod_p = p; mod_q = q; mod_r = r; inv_q = iq; half_p = hp; half_q = hq;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    s_o = sig;
    f_o = fault;
  endtask

  initial begin
    logic [63:0] s_o, s_e, hp, hq;
    logic        f_o, f_e;
    logic [31:0] iq;
    int          cyc, extra;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {63'b0, done}, 64'h0);
    chk("R1 fault in reset", {63'b0, fault}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sig after reset", sig, 64'h0);

    // table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      hp = VM[i] % ({32'b0, VP[i]} * {32'b0, VR[i]});
      hq = VM[i] % ({32'b0, VQ[i]} * {32'b0, VR[i]});
      iq = modinv(VQ[i] % VP[i], VP[i]);
      if (VK[i] == 1) hq = hq ^ 64'h1;
      if (VK[i] == 2) iq = (iq == VP[i] - 1) ? 32'd1 : iq + 32'd1;
      ref_model(VP[i], VQ[i], VR[i], iq, hp, hq, s_e, f_e);
      run_op(VP[i], VQ[i], VR[i], iq, hp, hq, s_o, f_o, cyc);
      chk($sformatf("R5/R7 sig vec%0d", i), s_o, s_e);
      chk($sformatf("R4/R7 fault vec%0d", i), {63'b0, f_o}, {63'b0, f_e});
      if (VK[i] == 0)
        chk($sformatf("R5 crt value vec%0d", i), s_o,
            VM[i] % ({32'b0, VP[i]} * {32'b0, VQ[i]}));
      if (VK[i] == 1) begin
        chk("R4 r mismatch flagged", {63'b0, f_o}, 64'h1);
        chk("R8 early exit latency", {63'b0, cyc <= LAT_ABORT}, 64'h1);
      end else begin
        chk($sformatf("R8 latency vec%0d", i), {63'b0, cyc <= LAT_FULL}, 64'h1);
      end
      if (i == 4) chk("R6 negative diff wrap", s_o, 64'd203);
      if (i == 6) chk("R7 wrong inverse flagged", {63'b0, f_o}, 64'h1);
      // R3: pulse is one cycle, outputs hold
      @(negedge clk);
      chk($sformatf("R3 done low after pulse vec%0d", i), {63'b0, done}, 64'h0);
      chk($sformatf("R3 sig held vec%0d", i), sig, s_o);
    end

    // R2: second start during busy and operand changes are ignored
    hp = VM[1] % ({32'b0, VP[1]} * {32'b0, VR[1]});
    hq = VM[1] % ({32'b0, VQ[1]} * {32'b0, VR[1]});
    iq = modinv(VQ[1] % VP[1], VP[1]);
    ref_model(VP[1], VQ[1], VR[1], iq, hp, hq, s_e, f_e);
    @(negedge clk);
    mod_p = VP[1]; mod_q = VQ[1]; mod_r = VR[1]; inv_q = iq; half_p = hp; half_q = hq;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mod_p = 32'd7; mod_q = 32'd11; mod_r = 32'd13; inv_q = 32'd3;
    half_p = 64'h55; half_q = 64'hAA;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R2 result from captured operands", sig, s_e);
    chk("R2 fault from captured operands", {63'b0, fault}, {63'b0, f_e});
    extra = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R2/R3 no second done", 64'(extra), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule